// File: doc/BRIEF.md
# Keyboard Wake-Up Interrupt Controller

This block watches a group of active-low keyboard lines on a small microcontroller port and raises one interrupt request when any key pulls its line low. All lines are combined by an AND into one active-low "any key" signal. That signal passes through a reset-to-high synchronizer chain, and its falling edges are then detected. A single 8-bit control/status register holds four fields: an enable bit, a read-only pending-request flag, a write-one-to-clear acknowledge bit and a trigger-sensitivity option. The option can be written once after reset. The block also turns on the port pull-ups while keyboard mode is enabled, and it presents a fixed interrupt vector address to the interrupt controller.

Two small state machines do the work. The request machine has the states `REQ_IDLE` and `REQ_PENDING`. It takes the transition *set* (`REQ_IDLE`→`REQ_PENDING`) on a falling edge of the synchronized combined line, or on a low combined line when level sensitivity is selected. It takes the transition *acknowledge* (`REQ_PENDING`→`REQ_IDLE`) on an acknowledge write when no set condition is present in the same cycle. Otherwise it takes *hold*. The option machine has the states `OPT_OPEN` and `OPT_LOCKED`. The first register write after reset loads the option bit and takes *lock* (`OPT_OPEN`→`OPT_LOCKED`). Only reset takes *reopen* back to `OPT_OPEN`.

Top module: `kbd_wake_irq`

## Requirements
- R1: Reset (rst_n low) clears the enable bit, the request flag and the option lock, and selects edge-only sensitivity. The register then reads 0x00 and irq is 0.
- R2: A low on any one key line is an event. When a line falls between two clock edges, the request flag reads 1 after the third rising edge that follows, and still reads 0 after the second.
- R3: With the option bit at 0 (edge-only), the request sets only on a high-to-low transition of the combined line. A line that stays low after acknowledge does not set it again, and a second key going low while another is held does not set it.
- R4: The first write after reset loads the option from wdata bit 3. Any later write leaves the option unchanged until the next reset.
- R5: Writing 1 to bit 2 (acknowledge) clears the request flag at that clock edge when no set condition is present. Bit 2 always reads 0.
- R6: With the option bit at 1 (edge-and-level), the request sets and stays set while the combined line is low, so an acknowledge has no effect. After the line returns high, an acknowledge clears it.
- R7: irq is the request flag AND the enable bit (bit 0). The request flag sets even while the enable bit is 0.
- R8: If a set condition and an acknowledge write occur at the same clock edge, the request flag is 1 after that edge.
- R9: vec_addr is always 0xFFF2 (vector high byte at 0xFFF2, low byte at 0xFFF3), and pullup_en equals the enable bit.
- R10: Register layout: bit 0 is enable (read/write), bit 1 is request (read-only, writes ignored), bit 2 is acknowledge, bit 3 is the option, and bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n | input | 8 | Active-low keyboard lines |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |
| pullup_en | output | 1 | Port pull-up enable |
| vec_addr | output | 16 | Interrupt vector address |

## Verification
The hardest case to reach is an acknowledge write that lands at exactly the edge where the synchronized falling edge is detected. The bench drives a key low, waits two edges and then issues the acknowledge, so the write meets the edge at the third edge. A second hard case is a level-mode acknowledge while the line is held low. Reaching it needs a fresh reset to reopen the write-once option before level sensitivity can be selected. A reference model updated on every clock follows all of this, and it is compared against the design's outputs on every cycle.

// File: rtl/kbw_pkg.sv
package kbw_pkg;

    typedef enum logic {
        REQ_IDLE    = 1'b0,
        REQ_PENDING = 1'b1
    } req_state_t;

    typedef enum logic {
        OPT_OPEN   = 1'b0,
        OPT_LOCKED = 1'b1
    } opt_state_t;

    localparam int BIT_EN   = 0;
    localparam int BIT_REQ  = 1;
    localparam int BIT_ACK  = 2;
    localparam int BIT_SENS = 3;

endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] key_n,
    output logic                 any_n_s,
    output logic                 fall
);

    logic                   comb_n;
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;

    // any line low pulls the combined line low
    assign comb_n = &key_n;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= comb_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign any_n_s = chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= any_n_s;
    end

    assign fall = prev_q & ~any_n_s;

    // a falling edge is a single-cycle pulse
    assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/kbw_detect.sv
module kbw_detect
    import kbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic low_i,
    input  logic lvl_mode_i,
    input  logic ack_i,
    output logic req_o
);

    req_state_t state_q, state_d;
    logic       set_cond;

    assign set_cond = fall_i | (lvl_mode_i & low_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: begin
                if (set_cond) state_d = REQ_PENDING;
            end
            REQ_PENDING: begin
                if (ack_i && !set_cond) state_d = REQ_IDLE;
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        req_o = (state_q == REQ_PENDING);
    end

    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> req_o);

    assert_edge_only_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode_i && !req_o && !fall_i) |=> !req_o);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !fall_i && !(lvl_mode_i && low_i)) |=> !req_o);

    assert_level_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode_i && low_i) |=> req_o);

    assert_edge_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && ack_i) |=> req_o);

endmodule

// File: rtl/kbw_csr.sv
module kbw_csr
    import kbw_pkg::*;
#(
    parameter int CSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    input  logic             req_i,
    output logic             en_o,
    output logic             sens_o,
    output logic             ack_o,
    output logic [CSR_W-1:0] rdata_o
);

    opt_state_t opt_q, opt_d;
    logic       sens_q, sens_d;
    logic       en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q  <= OPT_OPEN;
            sens_q <= 1'b0;
        end else begin
            opt_q  <= opt_d;
            sens_q <= sens_d;
        end
    end

    always_comb begin
        opt_d  = opt_q;
        sens_d = sens_q;
        unique case (opt_q)
            OPT_OPEN: begin
                if (we) begin
                    sens_d = wdata[BIT_SENS];
                    opt_d  = OPT_LOCKED;
                end
            end
            OPT_LOCKED: begin
                opt_d = OPT_LOCKED;
            end
            default: opt_d = OPT_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  en_q <= 1'b0;
        else if (we) en_q <= wdata[BIT_EN];
    end

    always_comb begin
        en_o     = en_q;
        sens_o   = sens_q;
        ack_o    = we & wdata[BIT_ACK];
        rdata_o  = '0;
        rdata_o[BIT_EN]   = en_q;
        rdata_o[BIT_REQ]  = req_i;
        rdata_o[BIT_SENS] = sens_q;
    end

    assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_q == OPT_LOCKED) |=> $stable(sens_q));

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_q == OPT_LOCKED) |=> (opt_q == OPT_LOCKED));

endmodule

// File: rtl/kbd_wake_irq.sv
module kbd_wake_irq
    import kbw_pkg::*;
#(
    parameter int          NUM_LINES   = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          CSR_W       = 8,
    parameter logic [15:0] VECTOR      = 16'hFFF2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] key_n,
    input  logic                 csr_we,
    input  logic [CSR_W-1:0]     csr_wdata,
    output logic [CSR_W-1:0]     csr_rdata,
    output logic                 irq,
    output logic                 pullup_en,
    output logic [15:0]          vec_addr
);

    logic any_n_s, fall, req, en, sens, ack;

    kbw_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_n   (key_n),
        .any_n_s (any_n_s),
        .fall    (fall)
    );

    kbw_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .low_i      (~any_n_s),
        .lvl_mode_i (sens),
        .ack_i      (ack),
        .req_o      (req)
    );

    kbw_csr #(.CSR_W(CSR_W)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (csr_we),
        .wdata   (csr_wdata),
        .req_i   (req),
        .en_o    (en),
        .sens_o  (sens),
        .ack_o   (ack),
        .rdata_o (csr_rdata)
    );

    assign irq       = req & en;
    assign pullup_en = en;
    assign vec_addr  = VECTOR;

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr_rdata[BIT_EN] && csr_rdata[BIT_REQ]));

    assert_ack_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> !csr_rdata[BIT_ACK]);

endmodule

// File: tb/kbd_wake_irq_test.sv
module kbd_wake_irq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  key_n = 8'hFF;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_wdata = 8'h00;
    logic [7:0]  csr_rdata;
    logic        irq, pullup_en;
    logic [15:0] vec_addr;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    bit m_q[$];
    bit m_en, m_req, m_sens, m_lock;

    always #2 clk = ~clk;

    kbd_wake_irq uut (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
        .pullup_en(pullup_en), .vec_addr(vec_addr)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_q = '{1'b1, 1'b1, 1'b1};
        m_en = 0; m_req = 0; m_sens = 0; m_lock = 0;
    endtask

    task automatic model_edge();
        bit fall_e, low_e, setc;
        fall_e = m_q[0] && !m_q[1];
        low_e  = !m_q[1];
        setc   = fall_e || (m_sens && low_e);
        if (setc) m_req = 1;
        else if (csr_we && csr_wdata[2]) m_req = 0;
        if (csr_we) begin
            m_en = csr_wdata[0];
            if (!m_lock) begin
                m_sens = csr_wdata[3];
                m_lock = 1;
            end
        end
        void'(m_q.pop_front());
        m_q.push_back(&key_n);
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) model_reset();
        else model_edge();
        #1;
        check({cur_req, " rdata"}, {24'h0, csr_rdata},
              {24'h0, 4'h0, m_sens, 1'b0, m_req, m_en});
        check({cur_req, " irq"}, {31'h0, irq}, {31'h0, m_req & m_en});
        check("R9 pullup", {31'h0, pullup_en}, {31'h0, m_en});
        check("R9 vector", {16'h0, vec_addr}, 32'h0000FFF2);
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic wr(logic [7:0] d);
        csr_we = 1'b1;
        csr_wdata = d;
        tick();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        key_n = 8'hFF;
        tick();
        check("R1 reset rdata", {24'h0, csr_rdata}, 32'h0);
        check("R1 reset irq", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        ticks(4);
    endtask

    initial begin
        model_reset();
        cur_req = "R1";
        do_reset();

        // R10 / R4: edge mode, enable, lock
        cur_req = "R10";
        wr(8'h03);                         // bit1 write ignored
        check("R10 req not writable", {31'h0, csr_rdata[1]}, 32'h0);
        cur_req = "R4";
        wr(8'h09);                         // option write after lock ignored
        check("R4 option locked", {31'h0, csr_rdata[3]}, 32'h0);
        wr(8'h01);

        // R2 latency
        cur_req = "R2";
        key_n = 8'hF7;
        ticks(2);
        check("R2 not yet set", {31'h0, csr_rdata[1]}, 32'h0);
        tick();
        check("R2 set on third edge", {31'h0, csr_rdata[1]}, 32'h1);
        check("R7 irq asserted", {31'h0, irq}, 32'h1);

        // R3: held line after ack, second key
        cur_req = "R3";
        wr(8'h05);
        check("R5 ack clears", {31'h0, csr_rdata[1]}, 32'h0);
        check("R5 ack reads zero", {31'h0, csr_rdata[2]}, 32'h0);
        ticks(4);
        check("R3 held line no reset", {31'h0, csr_rdata[1]}, 32'h0);
        key_n = 8'h77;
        ticks(5);
        check("R3 second key ignored", {31'h0, csr_rdata[1]}, 32'h0);
        key_n = 8'hFF;
        ticks(4);
        key_n = 8'h7F;
        ticks(4);
        check("R3 new edge sets", {31'h0, csr_rdata[1]}, 32'h1);

        // R7: request while disabled
        cur_req = "R7";
        wr(8'h04);
        key_n = 8'hFF;
        ticks(4);
        key_n = 8'hFD;
        ticks(4);
        check("R7 req sets disabled", {31'h0, csr_rdata[1]}, 32'h1);
        check("R7 irq gated", {31'h0, irq}, 32'h0);
        wr(8'h01);
        check("R7 irq after enable", {31'h0, irq}, 32'h1);
        wr(8'h05);
        key_n = 8'hFF;
        ticks(4);

        // R8: edge and ack at the same edge
        cur_req = "R8";
        key_n = 8'hFE;
        ticks(2);
        wr(8'h05);
        check("R8 edge wins over ack", {31'h0, csr_rdata[1]}, 32'h1);
        key_n = 8'hFF;
        ticks(4);

        // R1 again, then level mode R6
        cur_req = "R1";
        do_reset();
        cur_req = "R6";
        wr(8'h09);
        check("R4 first write loads option", {31'h0, csr_rdata[3]}, 32'h1);
        key_n = 8'hBF;
        ticks(4);
        check("R6 level sets", {31'h0, csr_rdata[1]}, 32'h1);
        wr(8'h0D);
        check("R6 ack ignored while low", {31'h0, csr_rdata[1]}, 32'h1);
        ticks(3);
        wr(8'h0D);
        check("R6 still set while low", {31'h0, csr_rdata[1]}, 32'h1);
        key_n = 8'hFF;
        ticks(4);
        check("R6 latched after release", {31'h0, csr_rdata[1]}, 32'h1);
        wr(8'h05);
        check("R6 ack after release", {31'h0, csr_rdata[1]}, 32'h0);
        check("R4 option kept", {31'h0, csr_rdata[3]}, 32'h1);
        ticks(4);
        check("R6 stays clear when high", {31'h0, csr_rdata[1]}, 32'h0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule